// File: doc/BRIEF.md
# Parity-Framed Identifier Transmitter

This block turns a fixed 40-bit identifier into a repeating 64-bit frame and drives it, Manchester coded, onto a single modulation control line. The identifier holds 8 version bits in its top byte and 32 data bits below them. The frame opens with a run of nine ones. Ten groups of four identifier bits follow, each closed by an even parity bit. A group of four even column-parity bits comes next, and a single zero ends the frame. A reader uses the run of ones to find the frame and uses the two parity dimensions to reject corrupted reads.

The block is clocked by the recovered RF carrier, with one clock per RF period. Every frame bit lasts 64 clocks. The level in the first 32 clocks equals the bit value and the level in the last 32 clocks is its inverse. When the stop bit ends, the first header bit follows with no gap. This continues for as long as the block is out of reset. The identifier input is treated as static.

Top module: `idtx_top`

## Requirements
- R1: While reset is asserted, and in the first clock after it is released, the block sits at frame bit 0 in its first half, so mod_ctl is 1. The first header half-bit then lasts exactly 32 clocks.
- R2: Frame bits 0 to 8 (in send order) are all 1.
- R3: Frame bits 9 to 58 form ten rows of five bits. Row r (r = 0..9) carries id_code[39-4r], id_code[38-4r], id_code[37-4r] and id_code[36-4r], in that order, then a bit that makes the row's five bits even. Rows 0 and 1 therefore carry the version byte id_code[39:32].
- R4: Frame bits 59 to 62 are column parity bits. Bit 59+k is the XOR of data bit k of all ten rows, so each column is even. No row parity follows them.
- R5: Frame bit 63 is a stop bit of 0, and the frame is exactly 64 bits long.
- R6: Each frame bit lasts 64 clocks. mod_ctl equals the bit value for the first 32 clocks and its inverse for the last 32, so every bit has a transition at its middle.
- R7: After frame bit 63, transmission continues with frame bit 0 on the next clock. The same frame repeats indefinitely.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_rf | input | 1 | RF-derived clock, one cycle per carrier period |
| rst_n | input | 1 | Synchronous active-low reset |
| id_code | input | 40 | Static identifier: version byte in [39:32], data in [31:0] |
| mod_ctl | output | 1 | Registered modulation control line, Manchester coded |

## Verification
A wrong bit or half-bit counter shifts every later edge of mod_ctl. The per-clock comparison against the reference position therefore reports such an error within one half-bit (32 clocks) of the first slip. A mistake in frame assembly, such as a wrong parity, row order or stop value, shows up as a wrong level within the first frame (4096 clocks). The Manchester decoder in the bench flags it again on its structural frame checks. A wrap-around error shows at the first repetition, so two frames are decoded per identifier.

// File: rtl/idtx_pkg.sv
// Package: idtx_pkg
// Shared frame geometry for the identifier transmitter. All counts derive
// from the header length, row count, row width and clocks per bit.
package idtx_pkg;
    localparam int HDR_BITS  = 9;
    localparam int ROW_CNT   = 10;
    localparam int ROW_DATA  = 4;
    localparam int BIT_CLKS  = 64;
    localparam int ID_BITS   = ROW_CNT * ROW_DATA;
    localparam int FRAME_LEN = HDR_BITS + ROW_CNT * (ROW_DATA + 1) + ROW_DATA + 1;
endpackage

// File: rtl/idtx_frame_build.sv
// Module: idtx_frame_build
// Purely combinational frame assembly. frame_o[0] is the first bit sent.
// Layout: header of ones, rows of data plus even parity (most significant
// identifier bit first), a column-parity row, then a zero stop bit.
// Assumes id_i is static while the frame is being sent.
module idtx_frame_build #(
    parameter int HDR_BITS = 9,
    parameter int ROW_CNT  = 10,
    parameter int ROW_DATA = 4,
    localparam int ID_BITS   = ROW_CNT * ROW_DATA,
    localparam int ROW_W     = ROW_DATA + 1,
    localparam int COL_BASE  = HDR_BITS + ROW_CNT * ROW_W,
    localparam int FRAME_LEN = COL_BASE + ROW_DATA + 1
) (
    input  logic [ID_BITS-1:0]   id_i,
    output logic [FRAME_LEN-1:0] frame_o
);
    logic [ROW_DATA-1:0] col_par;

    // Header: a run of ones.
    genvar h;
    generate
        for (h = 0; h < HDR_BITS; h++) begin : g_hdr
            assign frame_o[h] = 1'b1;
        end
    endgenerate

    // Data rows: four identifier bits, MSB first, then even parity.
    genvar r, k;
    generate
        for (r = 0; r < ROW_CNT; r++) begin : g_row
            logic [ROW_DATA-1:0] nib;
            for (k = 0; k < ROW_DATA; k++) begin : g_bit
                assign nib[k] = id_i[ID_BITS-1-(r*ROW_DATA+k)];
                assign frame_o[HDR_BITS + r*ROW_W + k] = nib[k];
            end
            assign frame_o[HDR_BITS + r*ROW_W + ROW_DATA] = ^nib;
        end
    endgenerate

    // Column parity: XOR of the same data position across all rows.
    always_comb begin
        col_par = '0;
        for (int rr = 0; rr < ROW_CNT; rr++) begin
            for (int kk = 0; kk < ROW_DATA; kk++) begin
                col_par[kk] = col_par[kk] ^ id_i[ID_BITS-1-(rr*ROW_DATA+kk)];
            end
        end
    end

    genvar c;
    generate
        for (c = 0; c < ROW_DATA; c++) begin : g_col
            assign frame_o[COL_BASE + c] = col_par[c];
        end
    endgenerate

    // Stop bit.
    assign frame_o[FRAME_LEN-1] = 1'b0;
endmodule

// File: rtl/idtx_bit_seq.sv
// Module: idtx_bit_seq
// Position sequencer: a clock-within-bit counter and a frame bit index.
// It publishes both the current and the next position so the encoder can
// register its output without a lag. Wraps from the last bit to bit 0.
// Assumes BIT_CLKS is even (two equal halves).
module idtx_bit_seq #(
    parameter int BIT_CLKS  = 64,
    parameter int FRAME_LEN = 64,
    localparam int CNT_W = $clog2(BIT_CLKS),
    localparam int IDX_W = $clog2(FRAME_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt_q,
    output logic [IDX_W-1:0] idx_q,
    output logic [CNT_W-1:0] cnt_nxt,
    output logic [IDX_W-1:0] idx_nxt
);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(BIT_CLKS - 1);
    localparam logic [IDX_W-1:0] IDX_MAX = IDX_W'(FRAME_LEN - 1);

    logic bit_end;

    // Next-position computation with wrap at bit end and frame end.
    always_comb begin
        bit_end = (cnt_q == CNT_MAX);
        cnt_nxt = bit_end ? '0 : cnt_q + 1'b1;
        if (bit_end)
            idx_nxt = (idx_q == IDX_MAX) ? '0 : idx_q + 1'b1;
        else
            idx_nxt = idx_q;
    end

    // Position registers; reset places the block at bit 0, clock 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            idx_q <= '0;
        end else begin
            cnt_q <= cnt_nxt;
            idx_q <= idx_nxt;
        end
    end

    // R6
    idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != CNT_MAX) |=> $stable(idx_q));

    // R7
    frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_q == IDX_MAX && cnt_q == CNT_MAX) |=> (idx_q == '0 && cnt_q == '0));
endmodule

// File: rtl/idtx_manch_enc.sv
// Module: idtx_manch_enc
// Manchester encoder with a registered output. Level = bit XOR second-half,
// so a 1 is high then low and a 0 low then high. It uses the sequencer's next
// position so the register always matches the current position.
module idtx_manch_enc #(
    parameter int BIT_CLKS  = 64,
    parameter int FRAME_LEN = 64,
    localparam int CNT_W = $clog2(BIT_CLKS),
    localparam int IDX_W = $clog2(FRAME_LEN),
    localparam int HALF  = BIT_CLKS / 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [FRAME_LEN-1:0] frame_i,
    input  logic [CNT_W-1:0]     cnt_q,
    input  logic [CNT_W-1:0]     cnt_nxt,
    input  logic [IDX_W-1:0]     idx_nxt,
    output logic                 mod_o
);
    localparam logic [CNT_W-1:0] HALF_C = CNT_W'(HALF);

    logic lvl_nxt;

    // Level for the upcoming position.
    always_comb begin
        lvl_nxt = frame_i[idx_nxt] ^ (cnt_nxt >= HALF_C);
    end

    // Output register; in reset it shows the first half of frame bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mod_o <= frame_i[0];
        else
            mod_o <= lvl_nxt;
    end

    // R6
    edge_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mod_o) |-> (cnt_q == '0 || cnt_q == HALF_C));

    // R6
    mid_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == HALF_C - 1'b1) |=> (mod_o != $past(mod_o)));
endmodule

// File: rtl/idtx_top.sv
// Module: idtx_top
// Parity-framed identifier transmitter. Builds the 64-bit frame from a static
// identifier and sends it endlessly, Manchester coded, on mod_ctl.
// Assumes one clk_rf cycle per RF period and a static id_code.
module idtx_top
    import idtx_pkg::*;
(
    input  logic               clk_rf,
    input  logic               rst_n,
    input  logic [ID_BITS-1:0] id_code,
    output logic               mod_ctl
);
    localparam int CNT_W    = $clog2(BIT_CLKS);
    localparam int IDX_W    = $clog2(FRAME_LEN);
    localparam int ROW_W    = ROW_DATA + 1;
    localparam int COL_BASE = HDR_BITS + ROW_CNT * ROW_W;

    logic [FRAME_LEN-1:0] frame;
    logic [CNT_W-1:0]     cnt_q, cnt_nxt;
    logic [IDX_W-1:0]     idx_q, idx_nxt;

    idtx_frame_build #(
        .HDR_BITS(HDR_BITS), .ROW_CNT(ROW_CNT), .ROW_DATA(ROW_DATA)
    ) u_frame (
        .id_i(id_code), .frame_o(frame)
    );

    idtx_bit_seq #(
        .BIT_CLKS(BIT_CLKS), .FRAME_LEN(FRAME_LEN)
    ) u_seq (
        .clk(clk_rf), .rst_n(rst_n),
        .cnt_q(cnt_q), .idx_q(idx_q),
        .cnt_nxt(cnt_nxt), .idx_nxt(idx_nxt)
    );

    idtx_manch_enc #(
        .BIT_CLKS(BIT_CLKS), .FRAME_LEN(FRAME_LEN)
    ) u_enc (
        .clk(clk_rf), .rst_n(rst_n), .frame_i(frame),
        .cnt_q(cnt_q), .cnt_nxt(cnt_nxt), .idx_nxt(idx_nxt),
        .mod_o(mod_ctl)
    );

    // Row and column parity checks on the assembled frame.
    genvar r, k;
    generate
        for (r = 0; r < ROW_CNT; r++) begin : g_rchk
            // R3
            row_par_chk: assert property (@(posedge clk_rf) disable iff (!rst_n)
                (^frame[HDR_BITS + r*ROW_W +: ROW_W]) == 1'b0);
        end
        for (k = 0; k < ROW_DATA; k++) begin : g_cchk
            logic col_x;
            // Column XOR including its parity bit must be zero.
            always_comb begin
                col_x = frame[COL_BASE + k];
                for (int rr = 0; rr < ROW_CNT; rr++)
                    col_x = col_x ^ frame[HDR_BITS + rr*ROW_W + k];
            end
            // R4
            col_par_chk: assert property (@(posedge clk_rf) disable iff (!rst_n)
                col_x == 1'b0);
        end
    endgenerate

    // R1
    reset_level_chk: assert property (@(posedge clk_rf)
        $rose(rst_n) |-> (mod_ctl == 1'b1));
endmodule

// File: tb/tb_idtx_top.sv
module tb_idtx_top;
    logic        clk_rf = 1'b0;
    logic        rst_n  = 1'b0;
    logic [39:0] id_code = '0;
    logic        mod_ctl;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    idtx_top dut (.clk_rf(clk_rf), .rst_n(rst_n), .id_code(id_code), .mod_ctl(mod_ctl));

    always #10 clk_rf = ~clk_rf;

    // Watchdog
    always @(posedge clk_rf) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual=%0d cycles expected<=150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Behavioural frame reference from the requirements.
    function automatic void build_ref(input logic [39:0] id, ref bit q[$]);
        bit col [4];
        q.delete();
        for (int i = 0; i < 4; i++) col[i] = 0;
        for (int i = 0; i < 9; i++) q.push_back(1);
        for (int r = 0; r < 10; r++) begin
            bit p = 0;
            for (int k = 0; k < 4; k++) begin
                bit b = id[39 - 4*r - k];
                q.push_back(b);
                p ^= b;
                col[k] ^= b;
            end
            q.push_back(p);
        end
        for (int k = 0; k < 4; k++) q.push_back(col[k]);
        q.push_back(0);
    endfunction

    // Structural checks on one decoded frame.
    task automatic check_frame(input bit d[$], input int base, input logic [39:0] id);
        bit cp [4];
        for (int i = 0; i < 4; i++) cp[i] = 0;
        for (int i = 0; i < 9; i++) chk("R2 header", d[base+i], 1'b1);
        for (int r = 0; r < 10; r++) begin
            bit p = 0;
            for (int k = 0; k < 5; k++) p ^= d[base + 9 + 5*r + k];
            chk("R3 row parity", p, 1'b0);
            for (int k = 0; k < 4; k++) begin
                chk("R3 row data", d[base + 9 + 5*r + k], id[39 - 4*r - k]);
                cp[k] ^= d[base + 9 + 5*r + k];
            end
        end
        for (int k = 0; k < 4; k++)
            chk("R4 column parity", cp[k] ^ d[base + 59 + k], 1'b0);
        chk("R5 stop", d[base+63], 1'b0);
    endtask

    task automatic run_id(input logic [39:0] id);
        bit ref_q[$];
        bit dec[$];
        bit h1, h2;
        int pos;
        build_ref(id, ref_q);
        @(negedge clk_rf);
        rst_n   = 1'b0;
        id_code = id;
        repeat (3) @(negedge clk_rf);
        chk("R1 reset level", mod_ctl, 1'b1);
        rst_n = 1'b1;
        pos = 0;
        h1 = 0;
        h2 = 0;
        // Two full frames plus the start of a third (R7 wrap).
        for (int n = 0; n < 2*64*64 + 200; n++) begin
            int c = pos % 64;
            int b = (pos / 64) % 64;
            logic exp = ref_q[b] ^ (c >= 32);
            if (n > 0) @(negedge clk_rf);
            if (pos >= 4096) chk("R7 repeat", mod_ctl, exp);
            else chk("R6 level", mod_ctl, exp);
            if (c == 16) h1 = mod_ctl;
            if (c == 48) h2 = mod_ctl;
            if (c == 63) begin
                chk("R6 mid transition", h1 ^ h2, 1'b1);
                dec.push_back(h1);
                if (dec.size() % 64 == 0)
                    check_frame(dec, dec.size() - 64, id);
            end
            if (pos == 31) chk("R1 first half end", mod_ctl, 1'b1);
            pos++;
        end
    endtask

    initial begin
        repeat (2) @(negedge clk_rf);
        run_id(40'hA5_3C0F96E1);
        run_id(40'h00_00000000);
        run_id(40'hFF_FFFFFFFF);
        run_id(40'h12_3456789A);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule